// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block is the control and status logic that sits between a CPU register bus and an analog-to-digital converter core. Its single 8-bit register holds four things: the conversion state (busy and completion flag), the interrupt enable, a mirror of the external pause condition, and a two-bit mask that says which hardware timer events may start a conversion. A start request from software is always accepted while the external-trigger mode input is low. The mask can add the zero-detect pulse of a free-running timer, the underflow pulse of a reload timer, or both.

The controller drives single-cycle start and abort strobes to the converter core and receives a done pulse from it. Several register bits act only when written with 0. Writing 0 to the busy bit aborts a conversion and writing 0 to the completion flag clears it. Writing 1 to either bit leaves it unchanged. The interrupt request is the completion flag gated by the enable bit.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After the asynchronous reset, the register reads 0x00, irq_o is low, and conv_start_o and conv_abort_o are low.
- R2: The register reads {busy, flag, irq_en, pause, sel[1:0], 0, 0} from bit 7 down to bit 0. A write loads irq_en from bit 5 and sel from bits 3:2. Bits 1 and 0 always read 0, and written values in bits 4, 1 and 0 are not stored.
- R3: A write with bit 1 set, made while ext_mode_i is 0 and the block is idle, raises conv_start_o in the write cycle, and busy reads 1 from the next cycle. If ext_mode_i is 1, or bit 1 is written as 0, no start occurs.
- R4: A frt_zero_i pulse starts an idle block only when sel[0] is 1. A rld_uflow_i pulse starts an idle block only when sel[1] is 1. A pulse from a source that is not selected is ignored.
- R5: Every start request that arrives while busy is 1 is ignored, and conv_start_o stays low.
- R6: A write with bit 7 equal to 0 while busy is 1 raises conv_abort_o in that cycle, and busy reads 0 on the next cycle. The abort does not set the flag. Writing bit 7 as 1, or writing it while idle, has no effect.
- R7: conv_done_i while busy is 1 clears busy and sets the flag on the next cycle. conv_done_i while idle is ignored. If an abort happens in the same cycle, the abort wins and the flag is not set.
- R8: A write with bit 6 equal to 0 clears the flag, and a write with bit 6 equal to 1 leaves it unchanged. A flag set by conv_done_i takes priority over a clear in the same cycle.
- R9: irq_o is high exactly when both irq_en and the flag are 1.
- R10: The pause bit (bit 4) shows the value of pause_i from the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| ext_mode_i | input | 1 | External-trigger mode; 1 blocks software start |
| frt_zero_i | input | 1 | Free-running timer zero-detect pulse, synchronous |
| rld_uflow_i | input | 1 | Reload timer underflow pulse, synchronous |
| pause_i | input | 1 | Pause condition from the transfer service |
| conv_done_i | input | 1 | Conversion complete pulse from the core |
| conv_start_o | output | 1 | Start strobe to the core |
| conv_abort_o | output | 1 | Abort strobe to the core |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong busy bit shows at the ports in two ways. A start strobe may appear while a conversion is running. A done or abort may be dropped, so busy stays at 1 and every later start is blocked. Both show up within one cycle of the next trigger. A fault in the flag or enable priority shows directly on irq_o and in bits 6 and 5 of the readback on the cycle after the event. A bad mask decode gives a start strobe in the same cycle as a timer pulse it should ignore, or no strobe where one is expected.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int CSR_W      = 8;
  localparam int NUM_HW_SRC = 2;

  localparam int BIT_BUSY  = 7;
  localparam int BIT_FLAG  = 6;
  localparam int BIT_IE    = 5;
  localparam int BIT_PAUSE = 4;
  localparam int BIT_SEL   = 2;
  localparam int BIT_START = 1;

  typedef struct packed {
    logic                  busy;
    logic                  flag;
    logic                  ie;
    logic                  pause;
    logic [NUM_HW_SRC-1:0] sel;
    logic                  start;
    logic                  rsvd;
  } csr_t;
endpackage

// File: rtl/adc_trig_src.sv
module adc_trig_src #(
  parameter int N = 2
) (
  input  logic [N-1:0] sel_i,
  input  logic [N-1:0] hw_evt_i,
  input  logic         sw_req_i,
  output logic         start_req_o
);
  logic [N-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign gated[g] = sel_i[g] & hw_evt_i[g];
  end

  assign start_req_o = sw_req_i | (|gated);
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic abort_req_i,
  input  logic done_i,
  input  logic flag_clr_i,
  output logic busy_o,
  output logic flag_o,
  output logic conv_start_o,
  output logic conv_abort_o
);
  logic busy_q, flag_q, flag_set;

  assign conv_start_o = start_req_i & ~busy_q;
  assign conv_abort_o = abort_req_i & busy_q;
  // abort beats done when coincident
  assign flag_set     = done_i & busy_q & ~conv_abort_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (conv_abort_o || flag_set) busy_q <= 1'b0;
      else if (conv_start_o)        busy_q <= 1'b1;

      if (flag_set)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/adc_trig_cfg.sv
module adc_trig_cfg #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         ie_i,
  input  logic [N-1:0] sel_i,
  input  logic         pause_i,
  output logic         ie_o,
  output logic [N-1:0] sel_o,
  output logic         pause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o    <= 1'b0;
      sel_o   <= '0;
      pause_o <= 1'b0;
    end else begin
      pause_o <= pause_i;
      if (wr_i) begin
        ie_o  <= ie_i;
        sel_o <= sel_i;
      end
    end
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [CSR_W-1:0] reg_wdata_i,
  output logic [CSR_W-1:0] reg_rdata_o,
  input  logic             ext_mode_i,
  input  logic             frt_zero_i,
  input  logic             rld_uflow_i,
  input  logic             pause_i,
  input  logic             conv_done_i,
  output logic             conv_start_o,
  output logic             conv_abort_o,
  output logic             irq_o
);
  logic                  sw_req, abort_req, flag_clr, start_req;
  logic                  busy, flag, ie, pause;
  logic [NUM_HW_SRC-1:0] sel;
  csr_t                  rd;
  logic                  unused_wdata;

  assign sw_req    = reg_wr_i & reg_wdata_i[BIT_START] & ~ext_mode_i;
  assign abort_req = reg_wr_i & ~reg_wdata_i[BIT_BUSY];
  assign flag_clr  = reg_wr_i & ~reg_wdata_i[BIT_FLAG];
  assign unused_wdata = ^{reg_wdata_i[BIT_PAUSE], reg_wdata_i[0]};

  adc_trig_src #(.N(NUM_HW_SRC)) u_src (
    .sel_i       (sel),
    .hw_evt_i    ({rld_uflow_i, frt_zero_i}),
    .sw_req_i    (sw_req),
    .start_req_o (start_req)
  );

  adc_trig_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_req_i  (start_req),
    .abort_req_i  (abort_req),
    .done_i       (conv_done_i),
    .flag_clr_i   (flag_clr),
    .busy_o       (busy),
    .flag_o       (flag),
    .conv_start_o (conv_start_o),
    .conv_abort_o (conv_abort_o)
  );

  adc_trig_cfg #(.N(NUM_HW_SRC)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .ie_i    (reg_wdata_i[BIT_IE]),
    .sel_i   (reg_wdata_i[BIT_SEL +: NUM_HW_SRC]),
    .pause_i (pause_i),
    .ie_o    (ie),
    .sel_o   (sel),
    .pause_o (pause)
  );

  always_comb begin
    rd       = '0;
    rd.busy  = busy;
    rd.flag  = flag;
    rd.ie    = ie;
    rd.pause = pause;
    rd.sel   = sel;
  end

  assign reg_rdata_o = rd;
  assign irq_o       = ie & flag;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       ext_mode_i,
  input logic       frt_zero_i,
  input logic       rld_uflow_i,
  input logic       pause_i,
  input logic       conv_done_i,
  input logic       conv_start_o,
  input logic       conv_abort_o,
  input logic       irq_o
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[1:0] == 2'b00);
  // R3
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> reg_rdata_o[7]);
  // R3
  ext_blocks_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && !frt_zero_i && !rld_uflow_i) |-> !conv_start_o);
  // R4
  unselected_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i && !(frt_zero_i && reg_rdata_o[2]) && !(rld_uflow_i && reg_rdata_o[3]))
    |-> !conv_start_o);
  // R5
  start_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !reg_rdata_o[7]);
  // R6
  abort_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_abort_o |=> !reg_rdata_o[7]);
  // R6
  abort_keeps_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_abort_o && reg_wdata_i[6]) |=> $stable(reg_rdata_o[6]));
  // R7
  done_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && reg_rdata_o[7] && !conv_abort_o) |=> (reg_rdata_o[6] && !reg_rdata_o[7]));
  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (reg_rdata_o[6] && reg_rdata_o[5]));
  // R10
  pause_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> reg_rdata_o[4]);
  // R10
  pause_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_i |=> !reg_rdata_o[4]);
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (.*);

// File: tb/sim_adc_trig_ctrl.sv
`timescale 1ns/1ps
module sim_adc_trig_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       ext_mode_i = 1'b0;
  logic       frt_zero_i = 1'b0;
  logic       rld_uflow_i = 1'b0;
  logic       pause_i = 1'b0;
  logic       conv_done_i = 1'b0;
  logic       conv_start_o, conv_abort_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  logic       m_busy = 1'b0, m_flag = 1'b0, m_ie = 1'b0, m_pause = 1'b0;
  logic [1:0] m_sel = 2'b00;

  always #4 clk_i = ~clk_i;

  adc_trig_ctrl u0 (.*);

  function automatic logic f_start(logic wr, logic [7:0] wd, logic ext, logic frt, logic rld);
    return !m_busy && ((wr && wd[1] && !ext) || (m_sel[0] && frt) || (m_sel[1] && rld));
  endfunction

  function automatic logic f_abort(logic wr, logic [7:0] wd);
    return wr && !wd[7] && m_busy;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic wr, logic [7:0] wd, logic ext, logic frt,
                      logic rld, logic done, logic pse);
    logic es, ea, fset;
    @(negedge clk_i);
    reg_wr_i = wr; reg_wdata_i = wd; ext_mode_i = ext; frt_zero_i = frt;
    rld_uflow_i = rld; conv_done_i = done; pause_i = pse;
    #1;
    es = f_start(wr, wd, ext, frt, rld);
    ea = f_abort(wr, wd);
    chk(req, "start R4", {7'd0, conv_start_o}, {7'd0, es});
    chk(req, "abort R6", {7'd0, conv_abort_o}, {7'd0, ea});
    chk(req, "rdata R2", reg_rdata_o, {m_busy, m_flag, m_ie, m_pause, m_sel, 2'b00});
    chk(req, "irq R9", {7'd0, irq_o}, {7'd0, m_ie & m_flag});
    @(posedge clk_i);
    fset = done && m_busy && !ea;
    if (ea || fset) m_busy = 1'b0;
    else if (es)    m_busy = 1'b1;
    if (fset)                m_flag = 1'b1;
    else if (wr && !wd[6])   m_flag = 1'b0;
    if (wr) begin m_ie = wd[5]; m_sel = wd[3:2]; end
    m_pause = pse;
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #150000;
    if (!ended) begin
      ended = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    #20;
    @(negedge clk_i);
    chk("R1", "reset rdata", reg_rdata_o, 8'h00);
    chk("R1", "reset irq", {7'd0, irq_o}, 8'h00);
    chk("R1", "reset strobes", {6'd0, conv_start_o, conv_abort_o}, 8'h00);
    rst_ni = 1'b1;

    // R2 and R3: store ie/sel, drop bits 4/1/0; ext mode blocks sw start
    step("R2", 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle("R2");
    // R4: mask 00 ignores both timers
    step("R4", 1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R3: start bit written 0 does nothing, then sw start
    step("R3", 1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R3", 1'b1, 8'hC2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5: starts while busy
    step("R5", 1'b1, 8'hCE, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7: done completes
    step("R7", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R9: enable irq, R8: write 1 keeps, write 0 clears
    step("R9", 1'b1, 8'hE0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R8", 1'b1, 8'hE0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R8", 1'b1, 8'hA0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: done while idle ignored
    step("R7", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R4: sel=01 frt start, reload ignored when sel=10 not set
    step("R4", 1'b1, 8'hE4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R4", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: abort, then abort attempt while idle
    step("R6", 1'b1, 8'h64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6", 1'b1, 8'h64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: sel=10 reload start
    step("R4", 1'b1, 8'hE8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R4", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R8: done beats clear in same cycle
    step("R8", 1'b1, 8'hA8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R7: abort and done together: no flag
    step("R7", 1'b1, 8'hA8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 8'hEA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 8'h68, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R10: pause mirror
    step("R10", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R10", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle("R10");

    for (int i = 0; i < 3000; i++) begin
      logic       wr;
      logic [7:0] wd;
      wr = ($urandom_range(7) == 0);
      wd = 8'($urandom);
      if ($urandom_range(3) != 0) wd[7] = 1'b1;
      if ($urandom_range(3) != 0) wd[6] = 1'b1;
      step("rand", wr, wd, 1'($urandom_range(3) == 0), 1'($urandom_range(5) == 0),
           1'($urandom_range(5) == 0), 1'($urandom_range(4) == 0), 1'($urandom));
    end
    idle("rand");

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule